// File: doc/BRIEF.md
# Threshold-Sweep Minimum Position Finder

This block finds where the smallest entry sits in a two-dimensional array of accumulated difference values. The default array is 19 rows by 25 columns. It does not walk the array entry by entry. It raises one shared threshold a level at a time, and every cell compares its own value against that threshold in the same cycle. The first level at which any cell falls below the threshold identifies the minimum. The block then stores that cell's column, its row and the level reached.

The whole array arrives on one flat input bus and must stay unchanged from the start pulse until the result comes back. The sweep uses a fixed number of levels, so the search time depends only on the level count and never on the number of cells. If every value is still at or above the top threshold after the last level, the block ends the search with valid low. The caller should then treat the region as unreliable and store no vector for it.

Top module: `gmin_sweep_locator`

## Requirements
- R1: After reset, done_o, valid_o and busy_o are low, and x_o, y_o and level_o are zero.
- R2: When the block is idle, a start_i high at a rising edge begins a sweep at level 0. At level k the threshold is STEP*(k+1), which is 32, 64, and so on up to 1024 with the defaults. A cell counts as below when its value is strictly less than the threshold.
- R3: If the first level with any cell below is k, done_o rises k+1 clock edges after the edge that accepted start_i. At that point valid_o is 1 and level_o is k.
- R4: x_o reports the column and y_o the row of the winning cell. Cell (row r, column c) has raster index r*COLS+c and occupies cells_i[idx*VAL_W +: VAL_W].
- R5: If several cells are below at the deciding level, the cell with the lowest raster index wins, even when another of those cells holds a smaller value.
- R6: If no cell is below at level LEVELS-1, with every value at least 1024 by default, done_o rises LEVELS edges after start. valid_o is then 0, level_o is LEVELS-1, and x_o and y_o are 0. No search takes longer than LEVELS cycles, whatever the array size.
- R7: busy_o is high from the edge that accepts start until the edge that raises done_o. A start_i pulse while busy_o is high neither restarts nor shortens the search.
- R8: Between searches, valid_o, x_o, y_o and level_o hold their values, and changing cells_i has no effect on them.
- R9: done_o is high for exactly one cycle per search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search when idle |
| cells_i | input | ROWS*COLS*VAL_W | All cell values, raster order, cell 0 in the low bits |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| valid_o | output | 1 | A minimum was found below the top threshold |
| x_o | output | clog2(COLS) | Column of the winning cell |
| y_o | output | clog2(ROWS) | Row of the winning cell |
| level_o | output | clog2(LEVELS) | Level at which the search ended |

## Verification
The result of a search is due at a known edge: the edge that raises done_o comes k+1 edges after the edge that accepts start, where k is the smallest entry divided by the step. A search that finds no cell below the threshold ends after exactly LEVELS edges. The bench drives start at a falling edge and counts falling edges until done_o is seen. It compares that count with the arithmetic k+1, then reads the position and level outputs in the same half-cycle. For the hold and ignore cases, the bench samples the outputs several falling edges after the disturbing stimulus, while the block is still idle.

// File: rtl/gmin_pkg.sv
package gmin_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;

    // Per-cycle decision of the sweep controller.
    typedef struct packed {
        logic accept;   // start taken while idle
        logic found;    // some cell is below the current threshold
        logic finish;   // search ends this cycle
        logic advance;  // move to the next level
    } sweep_ctl_t;

    // Threshold applied at a given level.
    function automatic int unsigned level_threshold(int unsigned lvl, int unsigned step);
        return step * (lvl + 1);
    endfunction

    function automatic int unsigned width_of(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gmin_level_ctr.sv
module gmin_level_ctr #(
    parameter int LEVELS = 32,
    parameter int STEP   = 32,
    parameter int LVL_W  = 5,
    parameter int THR_W  = 11
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    input  logic             advance_i,
    output logic [LVL_W-1:0] level_o,
    output logic [THR_W-1:0] thresh_o
);
    import gmin_pkg::*;

    logic [LVL_W-1:0] level_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            level_q <= '0;
        end else if (advance_i) begin
            level_q <= level_q + 1'b1;
        end
    end

    assign level_o  = level_q;
    assign thresh_o = THR_W'(level_threshold(int'(level_q), STEP));

endmodule

// File: rtl/gmin_below_array.sv
module gmin_below_array #(
    parameter int ROWS  = 19,
    parameter int COLS  = 25,
    parameter int VAL_W = 11,
    parameter int THR_W = 11
) (
    input  logic [ROWS*COLS*VAL_W-1:0] cells_i,
    input  logic [THR_W-1:0]           thresh_i,
    output logic [ROWS*COLS-1:0]       below_o
);
    localparam int CELLS = ROWS * COLS;
    localparam int CMP_W = (VAL_W > THR_W) ? VAL_W : THR_W;

    // One comparator per cell, all evaluated in the same cycle.
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        logic [VAL_W-1:0] val;
        assign val        = cells_i[i*VAL_W +: VAL_W];
        assign below_o[i] = CMP_W'(val) < CMP_W'(thresh_i);
    end

endmodule

// File: rtl/gmin_first_pick.sv
module gmin_first_pick #(
    parameter int ROWS = 19,
    parameter int COLS = 25,
    parameter int X_W  = 5,
    parameter int Y_W  = 5
) (
    input  logic [ROWS*COLS-1:0] below_i,
    output logic                 any_o,
    output logic [X_W-1:0]       col_o,
    output logic [Y_W-1:0]       row_o
);
    // Scan from the highest raster index down so the lowest set index
    // is the last one written and therefore wins.
    always_comb begin
        any_o = 1'b0;
        col_o = '0;
        row_o = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            for (int c = COLS - 1; c >= 0; c--) begin
                if (below_i[r*COLS + c]) begin
                    any_o = 1'b1;
                    row_o = Y_W'(r);
                    col_o = X_W'(c);
                end
            end
        end
    end

endmodule

// File: rtl/gmin_sweep_locator.sv
module gmin_sweep_locator #(
    parameter int ROWS   = 19,
    parameter int COLS   = 25,
    parameter int VAL_W  = 11,
    parameter int LEVELS = 32,
    parameter int STEP   = 32,
    localparam int X_W   = gmin_pkg::width_of(COLS),
    localparam int Y_W   = gmin_pkg::width_of(ROWS),
    localparam int LVL_W = gmin_pkg::width_of(LEVELS)
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       start_i,
    input  logic [ROWS*COLS*VAL_W-1:0] cells_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       valid_o,
    output logic [X_W-1:0]             x_o,
    output logic [Y_W-1:0]             y_o,
    output logic [LVL_W-1:0]           level_o
);
    import gmin_pkg::*;

    localparam int THR_W = $clog2(LEVELS * STEP + 1);
    localparam int CMP_W = (VAL_W > THR_W) ? VAL_W : THR_W;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    sweep_state_e      state_q;
    sweep_ctl_t        ctl;
    logic [LVL_W-1:0]  lvl;
    logic [THR_W-1:0]  thresh;
    logic [ROWS*COLS-1:0] below;
    logic              any_below;
    logic [X_W-1:0]    pick_col;
    logic [Y_W-1:0]    pick_row;

    gmin_level_ctr #(
        .LEVELS (LEVELS),
        .STEP   (STEP),
        .LVL_W  (LVL_W),
        .THR_W  (THR_W)
    ) u_level (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clear_i   (ctl.accept),
        .advance_i (ctl.advance),
        .level_o   (lvl),
        .thresh_o  (thresh)
    );

    gmin_below_array #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .VAL_W (VAL_W),
        .THR_W (THR_W)
    ) u_cmp (
        .cells_i  (cells_i),
        .thresh_i (thresh),
        .below_o  (below)
    );

    gmin_first_pick #(
        .ROWS (ROWS),
        .COLS (COLS),
        .X_W  (X_W),
        .Y_W  (Y_W)
    ) u_pick (
        .below_i (below),
        .any_o   (any_below),
        .col_o   (pick_col),
        .row_o   (pick_row)
    );

    always_comb begin
        ctl.accept  = (state_q == ST_IDLE) && start_i;
        ctl.found   = (state_q == ST_SWEEP) && any_below;
        ctl.finish  = (state_q == ST_SWEEP) && (any_below || (lvl == LAST_LVL));
        ctl.advance = (state_q == ST_SWEEP) && !ctl.finish;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b0;
            valid_o <= 1'b0;
            x_o     <= '0;
            y_o     <= '0;
            level_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (ctl.accept) begin
                state_q <= ST_SWEEP;
                valid_o <= 1'b0;
            end else if (ctl.finish) begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
                valid_o <= ctl.found;
                level_o <= lvl;
                x_o     <= ctl.found ? pick_col : '0;
                y_o     <= ctl.found ? pick_row : '0;
            end
        end
    end

    assign busy_o = (state_q == ST_SWEEP);

    // Value stored at the reported position, used by the checks below.
    logic [VAL_W-1:0] win_val;
    always_comb begin
        win_val = '0;
        if ((int'(x_o) < COLS) && (int'(y_o) < ROWS)) begin
            win_val = cells_i[(int'(y_o) * COLS + int'(x_o)) * VAL_W +: VAL_W];
        end
    end

    a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    a_r4_pos_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> ((int'(x_o) < COLS) && (int'(y_o) < ROWS)));

    a_r4_winner_below: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && valid_o) |->
            (CMP_W'(win_val) < CMP_W'(level_threshold(int'(level_o), STEP))));

    a_r6_miss_at_last: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !valid_o) |-> (level_o == LAST_LVL));

    a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && !start_i) |=> $stable({valid_o, x_o, y_o, level_o}));

    a_r7_no_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && start_i && !any_below && (lvl != LAST_LVL)) |=>
            (busy_o && (lvl == $past(lvl) + 1'b1)));

endmodule

// File: tb/gmin_sweep_locator_tb.sv
module gmin_sweep_locator_tb;

    localparam int ROWS   = 4;
    localparam int COLS   = 5;
    localparam int VAL_W  = 11;
    localparam int LEVELS = 32;
    localparam int STEP   = 32;
    localparam int N      = ROWS * COLS;
    localparam int X_W    = $clog2(COLS);
    localparam int Y_W    = $clog2(ROWS);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int VMAX   = (1 << VAL_W) - 1;

    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [N*VAL_W-1:0] cells;
    logic busy, done, valid;
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;
    logic [LVL_W-1:0] level;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int v [N];

    always #5 clk = ~clk;

    gmin_sweep_locator #(
        .ROWS(ROWS), .COLS(COLS), .VAL_W(VAL_W), .LEVELS(LEVELS), .STEP(STEP)
    ) u_dut (
        .clk_i(clk), .rst_i(rst), .start_i(start), .cells_i(cells),
        .busy_o(busy), .done_o(done), .valid_o(valid),
        .x_o(x), .y_o(y), .level_o(level)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            finish_run();
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load();
        for (int i = 0; i < N; i++) cells[i*VAL_W +: VAL_W] = VAL_W'(v[i]);
    endtask

    task automatic fill(int val);
        for (int i = 0; i < N; i++) v[i] = val;
    endtask

    // Runs one search and checks it against arithmetic expectations.
    // If poke > 0, start is pulsed again at that count while busy (R7).
    task automatic run_case(string tag, int poke);
        int m = VMAX;
        int k, win, lat;
        bit ok_valid;
        for (int i = 0; i < N; i++) if (v[i] < m) m = v[i];
        ok_valid = (m < LEVELS * STEP);
        k   = ok_valid ? m / STEP : LEVELS - 1;
        win = 0;
        if (ok_valid) begin
            for (int i = N - 1; i >= 0; i--) if (v[i] < STEP * (k + 1)) win = i;
        end
        @(negedge clk);
        load();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {tag, " R7 busy after start"}, int'(busy), 1);
        lat = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (done) break;
            if (poke > 0 && lat == poke) start = 1'b1;
            else start = 1'b0;
            if (lat > 40) break;
        end
        start = 1'b0;
        check(lat == k + 1, {tag, " R3/R6 latency"}, lat, k + 1);
        check(valid == ok_valid, {tag, " R3/R6 valid"}, int'(valid), int'(ok_valid));
        check(int'(level) == k, {tag, " R3 level"}, int'(level), k);
        check(int'(x) == (ok_valid ? win % COLS : 0), {tag, " R4/R5 x"}, int'(x),
              ok_valid ? win % COLS : 0);
        check(int'(y) == (ok_valid ? win / COLS : 0), {tag, " R4/R5 y"}, int'(y),
              ok_valid ? win / COLS : 0);
        @(negedge clk);
        check(done == 1'b0, {tag, " R9 done one cycle"}, int'(done), 0);
        check(busy == 1'b0, {tag, " R7 busy clear"}, int'(busy), 0);
    endtask

    initial begin
        int sx, sy, sl, sv;
        rst   = 1'b1;
        start = 1'b0;
        cells = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done == 0,  "R1 done",  int'(done), 0);
        check(valid == 0, "R1 valid", int'(valid), 0);
        check(busy == 0,  "R1 busy",  int'(busy), 0);
        check(x == 0 && y == 0, "R1 position", int'(x) + int'(y), 0);
        check(level == 0, "R1 level", int'(level), 0);

        // R4: minimum at every position, level 3 (R2 threshold 128)
        for (int p = 0; p < N; p++) begin
            fill(VMAX);
            v[p] = 100;
            run_case("pos", 0);
        end

        // R2/R3: every level reached once, other cells above its threshold
        for (int k = 0; k < LEVELS; k++) begin
            for (int i = 0; i < N; i++)
                v[i] = STEP * (k + 1) + int'($urandom_range(0, VMAX - STEP * (k + 1)));
            v[(k * 7) % N] = STEP * k + (k % STEP);
            run_case("level", 0);
        end

        // R2 boundaries: strictly-less-than compare
        fill(VMAX); v[9] = 31;   run_case("R2 31", 0);
        fill(VMAX); v[9] = 32;   run_case("R2 32", 0);
        fill(VMAX); v[4] = 0;    run_case("R2 zero", 0);
        fill(VMAX); v[18] = 1023; run_case("R2 1023", 0);

        // R6: nothing below the top threshold
        fill(1024); run_case("R6 1024", 0);
        fill(VMAX); run_case("R6 max", 0);

        // R5 ties
        fill(VMAX); v[7] = 500; v[13] = 500; run_case("R5 equal", 0);
        fill(VMAX); v[7] = 500; v[13] = 480; run_case("R5 same level", 0);
        fill(VMAX); v[1] = 520; v[2] = 510;  run_case("R5 diff level", 0);

        // R7: start pulsed mid-search is ignored
        fill(VMAX); v[11] = 330; run_case("R7 poke", 2);
        fill(VMAX); v[3] = 900;  run_case("R7 poke late", 20);

        // R8: outputs hold while idle and inputs change
        fill(VMAX); v[17] = 200; run_case("R8 setup", 0);
        sx = int'(x); sy = int'(y); sl = int'(level); sv = int'(valid);
        fill(0);
        load();
        repeat (6) @(negedge clk);
        check(int'(x) == sx && int'(y) == sy, "R8 position held", int'(x) * 8 + int'(y), sx * 8 + sy);
        check(int'(level) == sl, "R8 level held", int'(level), sl);
        check(int'(valid) == sv, "R8 valid held", int'(valid), sv);
        check(done == 0, "R8 no done while idle", int'(done), 0);

        // Random arrays
        for (int t = 0; t < 60; t++) begin
            for (int i = 0; i < N; i++) v[i] = int'($urandom_range(0, VMAX));
            if (t % 3 == 0) for (int i = 0; i < N; i++) v[i] = v[i] / 2 + 900;
            run_case("rand", 0);
        end

        finish_run();
    end

endmodule